// File: doc/BRIEF.md
# Dual-Port Scratchpad Buffer Controller

This block owns a small on-chip store of 16-bit Q8.8 words and sits between a host loader and a set of compute consumers. The host fills the store through two independent write lanes, each with its own valid flag. An internal write pointer places the words at consecutive addresses. When both lanes are valid in one cycle, two words are stored in that cycle.

A read transaction is launched by a one-cycle start pulse. The transaction latches:
- a 2-bit base selector, which picks one of four starting locations, 16 words apart by default;
- an 8-bit row count and a 2-bit column count;
- a transpose flag;
- a 3-bit destination code.

The controller then emits one word per cycle. It walks the rows-by-columns matrix either row-major or, when transposed, column-major. Each word is qualified by a one-hot valid bit on the lane of the chosen consumer. A busy level covers the fetch phase, and a done pulse follows the final word.

Top module: `spb_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and every bit of `rd_vld` are 0.
- R2: Host words go to consecutive addresses from a write pointer that starts at 0 and wraps modulo 64. When both lanes are valid, lane A takes the lower address and lane B the next one. A single valid lane takes one address. A cycle with neither lane valid stores nothing.
- R3: A start pulse seen while idle, with nonzero rows and columns, raises `busy` in the next cycle.
- R4: With transpose clear, element k of an R-by-C read is row k/C and column k%C. It is read from address (16*base + row*C + col) mod 64.
- R5: With transpose set, element k is column k/R and row k%R, using the same address formula.
- R6: The 2-bit base selects one of four starting offsets: 0, 16, 32 or 48.
- R7: `rd_vld` is one-hot. Bit d is set for destination code d (0 to 6). Code 7 sends no valid bit, while the read still runs and still ends with a done pulse.
- R8: The R*C words appear on consecutive cycles. The first one is visible in the second cycle after the clock edge that samples start.
- R9: `busy` falls together with the appearance of the last word. `done` is high for exactly the one cycle that follows the last word.
- R10: A start with zero rows or zero columns sends no valid word. It raises `done` for one cycle, right after the sampling edge, and `busy` stays low.
- R11: A start pulse, and any change of the read settings, while `busy` is high has no effect on the running stream. No extra transaction follows.
- R12: A 255-row read with three columns delivers all 765 words in both orders, with the address wrapping modulo 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_vld_a | input | 1 | Host lane A word valid |
| wr_dat_a | input | 16 | Host lane A Q8.8 word |
| wr_vld_b | input | 1 | Host lane B word valid |
| wr_dat_b | input | 16 | Host lane B Q8.8 word |
| rd_start | input | 1 | One-cycle read launch |
| rd_base | input | 2 | Starting location selector |
| rd_rows | input | 8 | Row count, 0 to 255 |
| rd_cols | input | 2 | Column count, 0 to 3 |
| rd_xpose | input | 1 | Column-major delivery when set |
| rd_dest | input | 3 | Destination code, 7 unused |
| rd_data | output | 16 | Streamed word |
| rd_vld | output | 7 | One-hot per-destination valid |
| busy | output | 1 | Fetch phase in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted write pointer or address counter shows up on the very first streamed word that touches the affected location. That word carries a value different from the arithmetic model of the store. A wrong loop bound or a lost end condition shows up at the word count: the valid stream runs short or long, or `busy` and `done` land a cycle off, at the end of the same transaction. A faulty destination decode is visible in every valid cycle as a wrong or multiple `rd_vld` bit. The sweep covers every base, column count, transpose setting and destination code over several row counts.

// File: rtl/spb_pkg.sv
package spb_pkg;

  // Read settings captured at transaction launch; field widths are fixed by
  // the command word that drives this block.
  typedef struct packed {
    logic [1:0] base;
    logic [7:0] rows;
    logic [1:0] cols;
    logic       xpose;
    logic [2:0] dest;
  } rd_cfg_t;

endpackage

// File: rtl/spb_wr_port.sv
module spb_wr_port #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_a,
  input  logic [DW-1:0] dat_a,
  input  logic          vld_b,
  input  logic [DW-1:0] dat_b,
  output logic          we0,
  output logic [AW-1:0] wa0,
  output logic [DW-1:0] wd0,
  output logic          we1,
  output logic [AW-1:0] wa1,
  output logic [DW-1:0] wd1,
  output logic [AW-1:0] wptr
);

  logic [AW-1:0] wptr_q, wptr_d;
  logic [1:0]    step;

  always_comb begin
    we0    = vld_a | vld_b;
    wa0    = wptr_q;
    wd0    = vld_a ? dat_a : dat_b;
    we1    = vld_a & vld_b;
    wa1    = wptr_q + AW'(1);
    wd1    = dat_b;
    step   = {1'b0, vld_a} + {1'b0, vld_b};
    wptr_d = wptr_q + AW'(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   wptr_q <= '0;
    else if (we0) wptr_q <= wptr_d;
  end

  assign wptr = wptr_q;

endmodule

// File: rtl/spb_store.sv
module spb_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we0,
  input  logic [AW-1:0] wa0,
  input  logic [DW-1:0] wd0,
  input  logic          we1,
  input  logic [AW-1:0] wa1,
  input  logic [DW-1:0] wd1,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we0) mem[wa0] <= wd0;
    if (we1) mem[wa1] <= wd1;
  end

  assign rdata = mem[ra];

endmodule

// File: rtl/spb_rd_seq.sv
module spb_rd_seq
  import spb_pkg::*;
#(
  parameter int AW          = 6,
  parameter int BASE_STRIDE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  rd_cfg_t       cfg_in,
  output logic          busy,
  output logic          fetch,
  output logic          last,
  output logic          zero_done,
  output logic [AW-1:0] addr,
  output rd_cfg_t       cfg
);

  localparam int SW = 16;

  rd_cfg_t    cfg_q;
  logic       busy_q, busy_d;
  logic [7:0] inner_q, inner_d, outer_q, outer_d;
  logic [7:0] inner_max, outer_max;
  logic [7:0] row_i, col_i;
  logic       accept, empty, inner_end, outer_end;
  logic [SW-1:0] sum;

  always_comb begin
    accept    = start & ~busy_q;
    empty     = (cfg_in.rows == 8'd0) | (cfg_in.cols == 2'd0);
    inner_max = cfg_q.xpose ? cfg_q.rows : {6'd0, cfg_q.cols};
    outer_max = cfg_q.xpose ? {6'd0, cfg_q.cols} : cfg_q.rows;
    inner_end = (inner_q == inner_max - 8'd1);
    outer_end = (outer_q == outer_max - 8'd1);

    busy_d  = busy_q;
    inner_d = inner_q;
    outer_d = outer_q;
    if (accept) begin
      busy_d  = ~empty;
      inner_d = '0;
      outer_d = '0;
    end else if (busy_q) begin
      if (inner_end) begin
        inner_d = '0;
        if (outer_end) busy_d  = 1'b0;
        else           outer_d = outer_q + 8'd1;
      end else begin
        inner_d = inner_q + 8'd1;
      end
    end

    row_i = cfg_q.xpose ? inner_q : outer_q;
    col_i = cfg_q.xpose ? outer_q : inner_q;
    sum   = SW'(row_i) * SW'(cfg_q.cols) + SW'(col_i)
          + SW'(BASE_STRIDE) * SW'(cfg_q.base);

    fetch     = busy_q;
    last      = busy_q & inner_end & outer_end;
    zero_done = accept & empty;
    addr      = sum[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      inner_q <= '0;
      outer_q <= '0;
    end else begin
      busy_q  <= busy_d;
      inner_q <= inner_d;
      outer_q <= outer_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (accept) cfg_q <= cfg_in;
  end

  assign busy = busy_q;
  assign cfg  = cfg_q;

endmodule

// File: rtl/spb_router.sv
module spb_router #(
  parameter int DW    = 16,
  parameter int NDEST = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch,
  input  logic             last,
  input  logic             zero_done,
  input  logic [2:0]       dest,
  input  logic [DW-1:0]    rdata,
  output logic [DW-1:0]    rd_data,
  output logic [NDEST-1:0] rd_vld,
  output logic             done
);

  logic [NDEST-1:0] sel;
  logic [NDEST-1:0] vld_q;
  logic [DW-1:0]    data_q;
  logic             last_q, done_q;

  for (genvar i = 0; i < NDEST; i++) begin : g_dec
    assign sel[i] = (dest == 3'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      last_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= fetch ? sel : '0;
      last_q <= last;
      done_q <= last_q | zero_done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (fetch) data_q <= rdata;
  end

  assign rd_data = data_q;
  assign rd_vld  = vld_q;
  assign done    = done_q;

endmodule

// File: rtl/spb_ctrl.sv
module spb_ctrl
  import spb_pkg::*;
#(
  parameter int DW          = 16,
  parameter int DEPTH       = 64,
  parameter int BASE_STRIDE = 16,
  parameter int NDEST       = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_vld_a,
  input  logic [DW-1:0]    wr_dat_a,
  input  logic             wr_vld_b,
  input  logic [DW-1:0]    wr_dat_b,
  input  logic             rd_start,
  input  logic [1:0]       rd_base,
  input  logic [7:0]       rd_rows,
  input  logic [1:0]       rd_cols,
  input  logic             rd_xpose,
  input  logic [2:0]       rd_dest,
  output logic [DW-1:0]    rd_data,
  output logic [NDEST-1:0] rd_vld,
  output logic             busy,
  output logic             done
);

  localparam int AW = $clog2(DEPTH);

  logic          rst_s0, rst_n_s;
  logic          we0, we1;
  logic [AW-1:0] wa0, wa1, wr_ptr, rd_addr;
  logic [DW-1:0] wd0, wd1, rdata;
  logic          fetch, last, zero_done;
  rd_cfg_t       cfg_in, cfg_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rst_s0  <= 1'b1;
      rst_n_s <= rst_s0;
    end
  end

  assign cfg_in = '{base: rd_base, rows: rd_rows, cols: rd_cols,
                    xpose: rd_xpose, dest: rd_dest};

  spb_wr_port #(.DW(DW), .AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n_s),
    .vld_a(wr_vld_a), .dat_a(wr_dat_a), .vld_b(wr_vld_b), .dat_b(wr_dat_b),
    .we0(we0), .wa0(wa0), .wd0(wd0), .we1(we1), .wa1(wa1), .wd1(wd1),
    .wptr(wr_ptr)
  );

  spb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk),
    .we0(we0), .wa0(wa0), .wd0(wd0), .we1(we1), .wa1(wa1), .wd1(wd1),
    .ra(rd_addr), .rdata(rdata)
  );

  spb_rd_seq #(.AW(AW), .BASE_STRIDE(BASE_STRIDE)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .start(rd_start), .cfg_in(cfg_in),
    .busy(busy), .fetch(fetch), .last(last), .zero_done(zero_done),
    .addr(rd_addr), .cfg(cfg_live)
  );

  spb_router #(.DW(DW), .NDEST(NDEST)) u_route (
    .clk(clk), .rst_n(rst_n_s), .fetch(fetch), .last(last),
    .zero_done(zero_done), .dest(cfg_live.dest), .rdata(rdata),
    .rd_data(rd_data), .rd_vld(rd_vld), .done(done)
  );

endmodule

// File: rtl/spb_ctrl_chk.sv
module spb_ctrl_chk
  import spb_pkg::*;
#(
  parameter int AW    = 6,
  parameter int NDEST = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_start,
  input logic [7:0]       rd_rows,
  input logic [1:0]       rd_cols,
  input logic             wr_vld_a,
  input logic             wr_vld_b,
  input logic [AW-1:0]    wptr,
  input rd_cfg_t          cfg_q,
  input logic             busy,
  input logic             done,
  input logic [NDEST-1:0] rd_vld
);

  // R2: a paired write advances the pointer by two
  p_wptr_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld_a && wr_vld_b) |=> (wptr == $past(wptr) + AW'(2)));

  // R3: accepted nonempty launch enters the fetch phase
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !busy && rd_rows != 8'd0 && rd_cols != 2'd0) |=> busy);

  // R7: at most one destination lane is valid
  p_vld_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_vld));

  // R7: unused destination code never raises a lane
  p_dest_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_q.dest == 3'd7) |=> (rd_vld == '0));

  // R8: a valid word follows a fetch cycle
  p_vld_after_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld != '0) |-> $past(busy));

  // R10: empty launch completes at once with no data
  p_empty_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !busy && (rd_rows == 8'd0 || rd_cols == 2'd0))
      |=> (done && !busy && rd_vld == '0));

  // R11: settings hold for the whole fetch phase
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q));

endmodule

bind spb_ctrl spb_ctrl_chk #(.AW(AW), .NDEST(NDEST)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .rd_start(rd_start), .rd_rows(rd_rows),
  .rd_cols(rd_cols), .wr_vld_a(wr_vld_a), .wr_vld_b(wr_vld_b),
  .wptr(wr_ptr), .cfg_q(cfg_live), .busy(busy), .done(done), .rd_vld(rd_vld)
);

// File: tb/tb_spb_ctrl.sv
module tb_spb_ctrl;

  localparam int DEPTH = 64;
  localparam int BSTR  = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_vld_a, wr_vld_b;
  logic [15:0] wr_dat_a, wr_dat_b;
  logic        rd_start, rd_xpose;
  logic [1:0]  rd_base, rd_cols;
  logic [7:0]  rd_rows;
  logic [2:0]  rd_dest;
  logic [15:0] rd_data;
  logic [6:0]  rd_vld;
  logic        busy, done;

  int checks = 0;
  int errors = 0;
  int model [DEPTH];
  int wp = 0;
  int seq_n = 0;

  always #5 clk = ~clk;

  spb_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .wr_vld_a(wr_vld_a), .wr_dat_a(wr_dat_a),
    .wr_vld_b(wr_vld_b), .wr_dat_b(wr_dat_b),
    .rd_start(rd_start), .rd_base(rd_base), .rd_rows(rd_rows),
    .rd_cols(rd_cols), .rd_xpose(rd_xpose), .rd_dest(rd_dest),
    .rd_data(rd_data), .rd_vld(rd_vld), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int pat(input int n);
    return (n * 16'h0359 + 16'h1234) & 16'hFFFF;
  endfunction

  task automatic host_wr(input bit va, input bit vb);
    int da = pat(seq_n);
    int db = va ? pat(seq_n + 1) : pat(seq_n);
    wr_vld_a = va; wr_dat_a = 16'(va ? da : 16'hDEAD);
    wr_vld_b = vb; wr_dat_b = 16'(vb ? db : 16'hBEEF);
    if (va) begin model[wp] = da; wp = (wp + 1) % DEPTH; seq_n++; end
    if (vb) begin model[wp] = db; wp = (wp + 1) % DEPTH; seq_n++; end
    @(negedge clk);
    wr_vld_a = 1'b0; wr_vld_b = 1'b0;
  endtask

  task automatic run_read(input int base, input int rows, input int cols,
                          input int x, input int dest, input bit inject,
                          input string tag);
    int n = rows * cols;
    int ev = (dest < 7) ? (1 << dest) : 0;
    rd_base = 2'(base); rd_rows = 8'(rows); rd_cols = 2'(cols);
    rd_xpose = x[0]; rd_dest = 3'(dest); rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    chk(busy == (n > 0), "R3 busy after start", int'(busy), int'(n > 0));
    chk(rd_vld == 7'd0, "R8 no word yet", int'(rd_vld), 0);
    chk(done == (n == 0), "R10 done on empty", int'(done), int'(n == 0));
    if (n == 0) begin
      chk(busy == 1'b0, "R10 idle on empty", int'(busy), 0);
      @(negedge clk);
      chk(done == 1'b0, "R10 single done", int'(done), 0);
      chk(rd_vld == 7'd0, "R10 no word", int'(rd_vld), 0);
    end else begin
      for (int k = 0; k < n; k++) begin
        int r, c, a;
        if (inject && k == 1) begin
          rd_start = 1'b1; rd_rows = 8'd7; rd_cols = 2'd1;
          rd_xpose = ~rd_xpose; rd_base = rd_base + 2'd1; rd_dest = 3'd0;
        end
        if (inject && k == 2) rd_start = 1'b0;
        @(negedge clk);
        if (x != 0) begin c = k / rows; r = k % rows; end
        else        begin r = k / cols; c = k % cols; end
        a = (base * BSTR + r * cols + c) % DEPTH;
        chk(int'(rd_vld) == ev, "R7 R8 lane valid", int'(rd_vld), ev);
        chk(int'(rd_data) == model[a], tag, int'(rd_data), model[a]);
        chk(busy == (k < n - 1), "R9 busy level", int'(busy), int'(k < n - 1));
      end
      @(negedge clk);
      chk(done == 1'b1, "R9 done after last", int'(done), 1);
      chk(rd_vld == 7'd0, "R9 stream ended", int'(rd_vld), 0);
      @(negedge clk);
      chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
      if (inject) begin
        chk(busy == 1'b0, "R11 no extra read", int'(busy), 0);
        @(negedge clk);
        chk(rd_vld == 7'd0, "R11 no extra word", int'(rd_vld), 0);
      end
    end
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_vld_a = 1'b0; wr_vld_b = 1'b0; wr_dat_a = '0; wr_dat_b = '0;
    rd_start = 1'b0; rd_base = '0; rd_rows = '0; rd_cols = '0;
    rd_xpose = 1'b0; rd_dest = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: quiet outputs after reset
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(rd_vld == 7'd0, "R1 lanes", int'(rd_vld), 0);

    // R2: paired, lane A only, lane B only, idle, then wrap over low words
    for (int i = 0; i < 16; i++) host_wr(1'b1, 1'b1);
    for (int i = 0; i < 16; i++) host_wr(1'b1, 1'b0);
    for (int i = 0; i < 16; i++) host_wr(1'b0, 1'b1);
    host_wr(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) host_wr(1'b1, 1'b1);
    repeat (2) @(negedge clk);

    // R4 R5 R6 R7: sweep bases, shapes, orders and destination codes
    begin
      int dsel = 0;
      int rset [5] = '{0, 1, 2, 3, 5};
      for (int b = 0; b < 4; b++)
        for (int ri = 0; ri < 5; ri++)
          for (int c = 0; c < 4; c++)
            for (int x = 0; x < 2; x++) begin
              run_read(b, rset[ri], c, x, dsel % 8, 1'b0,
                       (x != 0) ? "R2 R5 R6 word" : "R2 R4 R6 word");
              dsel++;
            end
    end

    // R11: start and settings changes mid-stream are ignored
    run_read(1, 5, 3, 0, 2, 1'b1, "R11 R4 word");
    run_read(2, 4, 2, 1, 6, 1'b1, "R11 R5 word");

    // R12: largest row count in both orders
    run_read(3, 255, 3, 0, 1, 1'b1, "R12 row-major word");
    run_read(0, 255, 3, 1, 4, 1'b0, "R12 column-major word");

    report();
    $finish;
  end

endmodule